// File: doc/BRIEF.md
# RS-485 UART with Hardware Direction Control

This block pairs a UART transmitter and a UART receiver for a half-duplex RS-485 line. It drives the transceiver's driver-enable and receiver-enable pins by itself, so the surrounding logic only offers bytes on a write port with a ready handshake and collects received bytes from a valid-flagged port. Frames carry one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. A runtime divisor sets the rate of the 16x oversampling tick that times both directions.

The node listens by default. It takes the bus only when a byte is waiting and the line is idle. The line counts as idle when no receive frame is in progress and the line has stayed high for a full character time. Bytes queued while a frame is going out follow it with no gap and without releasing the bus. The bus is released the moment the last stop bit ends. While the node drives the line, its receiver ignores the echo of its own data.

Top module: `rs485_autodir_uart`

## Requirements
- R1: After reset `de` is 0, `re_n` is 0 (receiver enabled), `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: `de` rises only while a byte is waiting and the bus is idle. Idle means no receive frame is in progress and the synchronized RX line has been high for 160 consecutive oversampling ticks (ten bit times). A byte written during a receive frame, or within a character time of reset, waits.
- R3: `de` falls exactly at the end of the stop bit of the last waiting byte: 10 bit times after the frame began.
- R4: `re_n` equals `de` on every clock, so direction needs no control beyond writing bytes.
- R5: A frame on `txd` is a 0 start bit, then data bits 0 through 7, then a 1 stop bit. Each bit lasts 16 ticks, and one tick occurs every `baud_div`+1 clocks.
- R6: A byte accepted while a frame is being sent starts right after that frame's stop bit, with `de` held high across the boundary.
- R7: A write is accepted on a clock where `tx_valid` and `tx_ready` are both 1. There is one holding slot, and `tx_ready` is 0 while it is occupied.
- R8: The receiver finds a start bit on a high-to-low transition and samples each bit at tick 7 of 16. It then pulses `rx_valid` for one clock with the byte on `rx_data`. `rx_ferr` is 1 when the sampled stop bit was 0.
- R9: While `de` is 1 the receiver treats RX as high, so the node's own echo produces no `rx_valid`.
- R10: `txd` is 1 whenever `de` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | 16 | Clocks per oversampling tick, minus one |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Holding slot free |
| txd | output | 1 | Serial data to transceiver driver |
| de | output | 1 | Transceiver driver enable |
| re_n | output | 1 | Transceiver receiver enable, active low |
| rxd | input | 1 | Serial data from transceiver receiver |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-clock pulse with a received byte |
| rx_ferr | output | 1 | Stop bit of that byte was low |

## Verification
The bench writes a byte right after reset and another during an incoming frame. It expects `de` to stay low until a full quiet character time has passed; a design that skipped the idle wait would collide with the other talker. It queues two bytes and checks that `de` never drops between them and falls on exactly the clock the last stop bit ends. A design that released early would cut off the stop bit, and one that released late would block the bus. The bench loops `txd` back onto `rxd` during transmission, where a receiver that listened would report phantom bytes. It also sends a frame with a low stop bit to show that the error flag is raised and that the receiver does not lock onto the still-low line as a new start. One run at a slower divisor exposes any rate logic tied to a single tick per clock.

// File: rtl/rs485_autodir_uart.sv
module rs485_autodir_uart #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              de,
  output logic              re_n,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ferr
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int OS_W       = $clog2(OSR);
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int IDLE_TICKS = OSR * FRAME_BITS;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);
  localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OSR - 1);
  localparam logic [OS_W-1:0]  OS_MID   = OS_W'(OSR / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_TICKS);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  assign tick = (div_cnt >= baud_div);

  always_ff @(posedge clk)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;

  logic [1:0] rx_sync;
  logic       rx_line;
  always_ff @(posedge clk)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};
  assign rx_line = de ? 1'b1 : rx_sync[1];

  logic              rx_busy, rx_prev;
  logic [OS_W-1:0]   rx_os;
  logic [BIT_W-1:0]  rx_idx;
  logic [DATA_W-1:0] rx_sh;

  logic [IDLE_W-1:0] idle_cnt;
  logic              bus_idle;
  assign bus_idle = (idle_cnt == IDLE_MAX);

  always_ff @(posedge clk)
    if (!rst_n)                   idle_cnt <= '0;
    else if (de)                  idle_cnt <= IDLE_MAX;
    else if (!rx_line || rx_busy) idle_cnt <= '0;
    else if (tick && !bus_idle)   idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_busy  <= 1'b0;
      rx_prev  <= 1'b1;
      rx_os    <= '0;
      rx_idx   <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        rx_prev <= rx_line;
        if (!rx_busy) begin
          if (rx_prev && !rx_line) begin
            rx_busy <= 1'b1;
            rx_os   <= '0;
            rx_idx  <= '0;
          end
        end else begin
          rx_os <= (rx_os == OS_LAST) ? '0 : rx_os + 1'b1;
          if (rx_os == OS_LAST) rx_idx <= rx_idx + 1'b1;
          if (rx_os == OS_MID) begin
            if (rx_idx == '0) begin
              if (rx_line) rx_busy <= 1'b0;
            end else if (rx_idx == BIT_LAST) begin
              rx_busy  <= 1'b0;
              rx_valid <= 1'b1;
              rx_data  <= rx_sh;
              rx_ferr  <= !rx_line;
            end else begin
              rx_sh <= {rx_line, rx_sh[DATA_W-1:1]};
            end
          end
        end
      end
    end
  end

  logic                  hold_v;
  logic [DATA_W-1:0]     hold_d;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [OS_W-1:0]       tx_os;
  logic [BIT_W-1:0]      tx_idx;
  logic                  accept, launch, tx_end, chain;

  assign tx_ready = !hold_v;
  assign accept   = tx_valid && !hold_v;
  assign launch   = !de && hold_v && bus_idle;
  assign tx_end   = de && tick && (tx_os == OS_LAST) && (tx_idx == BIT_LAST);
  assign chain    = tx_end && hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      de     <= 1'b0;
      tx_sh  <= '1;
      tx_os  <= '0;
      tx_idx <= '0;
    end else begin
      if (accept) begin
        hold_v <= 1'b1;
        hold_d <= tx_data;
      end else if (launch || chain) begin
        hold_v <= 1'b0;
      end
      if (launch || chain) begin
        de     <= 1'b1;
        tx_sh  <= {1'b1, hold_d, 1'b0};
        tx_os  <= '0;
        tx_idx <= '0;
      end else if (tx_end) begin
        de <= 1'b0;
      end else if (de && tick) begin
        if (tx_os == OS_LAST) begin
          tx_os  <= '0;
          tx_idx <= tx_idx + 1'b1;
          tx_sh  <= {1'b1, tx_sh[FRAME_BITS-1:1]};
        end else begin
          tx_os <= tx_os + 1'b1;
        end
      end
    end
  end

  assign txd  = de ? tx_sh[0] : 1'b1;
  assign re_n = de;

  p_take_needs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> $past(hold_v && bus_idle));
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> !txd);
  p_release_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(de) |-> $past(tx_idx == BIT_LAST && !hold_v));
  p_slot_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  p_no_listen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !rx_busy);
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: tb/rs485_autodir_uart_bench.sv
module rs485_autodir_uart_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, txd, de, re_n, rxd, rx_valid, rx_ferr;
  logic [7:0]  rx_data;
  logic        rxd_drv = 1'b1;
  logic        echo_en = 1'b0;

  int checks = 0;
  int errors = 0;
  int got_n = 0;
  logic [7:0] got_d;
  logic       got_f;
  logic [7:0] exp_b [0:1];
  bit finished = 1'b0;

  always #4 clk = ~clk;
  assign rxd = echo_en ? txd : rxd_drv;

  rs485_autodir_uart u_rs485_autodir_uart (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .de(de), .re_n(re_n), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk)
    if (rx_valid) begin
      got_n <= got_n + 1;
      got_d <= rx_data;
      got_f <= rx_ferr;
    end

  always @(negedge clk)
    if (rst_n) begin
      chk(re_n == de, "R4", "re_n vs de", int'(re_n), int'(de));
      chk(de || txd, "R10", "txd while released", int'(txd), 1);
    end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_expect(input int n, input int len, input int slack);
    int wait_n = 0;
    int total = n * 10 * len;
    while (!de && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(de, "R2", "driver taken", int'(de), 1);
    for (int i = 0; i < total; i++) begin
      int j = i / (10 * len);
      int k = (i % (10 * len)) / len;
      logic e;
      e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : exp_b[j][k-1];
      if (i % len == len / 2)
        chk(txd == e, "R5", $sformatf("byte %0d bit %0d", j, k), int'(txd), int'(e));
      if (i <= total - 1 - slack)
        chk(de, "R6", $sformatf("de held at %0d", i), int'(de), 1);
      @(negedge clk);
    end
    repeat (slack) @(negedge clk);
    chk(!de, "R3", "release after stop bit", int'(de), 0);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop, input int len);
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (len) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxd_drv = b[k];
      repeat (len) @(negedge clk);
    end
    rxd_drv = stop;
    repeat (len) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (len) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    chk(!de && !re_n && txd && tx_ready && !rx_valid, "R1", "reset state",
        {de, re_n, txd, tx_ready, rx_valid}, 5'b00110);
    rst_n = 1'b1;

    exp_b[0] = 8'hC3;
    put(8'hC3);
    repeat (100) @(negedge clk);
    chk(!de, "R2", "wait for quiet line after reset", int'(de), 0);
    chk(!tx_ready, "R7", "slot occupied while waiting", int'(tx_ready), 0);
    tx_expect(1, 16, 0);

    n0 = got_n;
    echo_en = 1'b1;
    exp_b[0] = 8'h55;
    exp_b[1] = 8'h0F;
    fork
      begin put(8'h55); put(8'h0F); end
      tx_expect(2, 16, 0);
    join
    repeat (40) @(negedge clk);
    echo_en = 1'b0;
    chk(got_n == n0, "R9", "echo ignored", got_n, n0);

    n0 = got_n;
    send_rx(8'hA5, 1'b1, 16);
    chk(got_n == n0 + 1, "R8", "frame count", got_n, n0 + 1);
    chk(got_d == 8'hA5 && !got_f, "R8", "good frame", {got_f, got_d}, 9'h0A5);

    send_rx(8'h3C, 1'b0, 16);
    repeat (40) @(negedge clk);
    chk(got_n == n0 + 2, "R8", "no false restart", got_n, n0 + 2);
    chk(got_d == 8'h3C && got_f, "R8", "framing error", {got_f, got_d}, 9'h13C);

    exp_b[0] = 8'h81;
    fork
      send_rx(8'h5A, 1'b1, 16);
      begin
        repeat (40) @(negedge clk);
        put(8'h81);
        chk(!tx_ready, "R7", "slot held during rx", int'(tx_ready), 0);
        chk(!de, "R2", "no take mid-frame", int'(de), 0);
      end
    join
    chk(got_d == 8'h5A, "R8", "frame under deferral", int'(got_d), 8'h5A);
    repeat (100) @(negedge clk);
    chk(!de, "R2", "no take before quiet time", int'(de), 0);
    tx_expect(1, 16, 0);

    baud_div = 16'd2;
    repeat (20) @(negedge clk);
    exp_b[0] = 8'h96;
    put(8'h96);
    tx_expect(1, 48, 3);
    send_rx(8'h6E, 1'b1, 48);
    chk(got_d == 8'h6E && !got_f, "R8", "slow rate frame", {got_f, got_d}, 9'h06E);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule